// File: doc/BRIEF.md
# Complex Accumulator with Bit-Growth Detection

This block is the auxiliary complex accumulator that sits beside a complex multiply-accumulate path when that path is used for FFT butterflies. Each cycle it takes one complex sample, already shifted and sign-aligned as a 16-bit fraction with its binary point just right of the sign bit. It either starts a new sum with that sample or adds the sample to the running sum. The choice follows the same accumulate control that drives the main multiply-accumulate path. The real and imaginary sums are 20 bits wide. This gives four integer bits of headroom above the input format, so the binary point of the result sits after the fifth most significant bit.

The block also reports how far the data has grown above unity magnitude. It looks at the top five bits of its own two sums and at the top five bits of the main multiply-accumulate result, real and imaginary, which the block receives as inputs. From these it forms a 2-bit growth code of 0 to 3 bits and registers it. A tracking control chooses the register's mode. In one mode the register follows the current growth every cycle. In the other it keeps the largest code seen, so software or a scaling controller can pick the right shift for the next FFT pass.

Top module: `cplx_accum_growth`

## Requirements
- R1: A synchronous active-high reset clears both accumulator outputs and the growth code to zero on the next clock edge.
- R2: When `acc_en` is 0 at a clock edge, each accumulator output becomes the 16-bit sample sign-extended to 20 bits.
- R3: When `acc_en` is 1 at a clock edge, each accumulator output becomes its previous value plus the sign-extended sample.
- R4: The real and imaginary accumulators are independent. The imaginary output depends only on `smp_im` and the shared `acc_en`.
- R5: The growth of a 20-bit value is taken from its bits [19:15]. It is 0 if those five bits are all equal, 1 if bits [19:16] are equal, 2 if bits [19:17] are equal, and 3 otherwise. Equivalently, it is 0, 1, 2 or 3 for a value within ±2^15, ±2^16, ±2^17, or beyond.
- R6: The current growth is the maximum over four 5-bit fields: the top bits of `acc_re`, the top bits of `acc_im`, `mac_re_hi` and `mac_im_hi`, each treated like bits [19:15] under R5. The accumulator fields are taken from the outputs before the edge that loads the growth register.
- R7: When `track_live` is 1 at a clock edge, `growth` is loaded with the current growth.
- R8: When `track_live` is 0 at a clock edge, `growth` is loaded with the larger of its own value and the current growth, so it never decreases.
- R9: A sum that leaves the 20-bit range wraps around modulo 2^20, as in two's complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_re | input | 16 | Pre-shifted real sample, signed fraction |
| smp_im | input | 16 | Pre-shifted imaginary sample, signed fraction |
| acc_en | input | 1 | 1 adds to the running sum, 0 restarts the sum with the sample |
| track_live | input | 1 | 1 makes the growth register follow, 0 holds the peak |
| mac_re_hi | input | 5 | Bits [19:15] of the main real multiply-accumulate result |
| mac_im_hi | input | 5 | Bits [19:15] of the main imaginary multiply-accumulate result |
| acc_re | output | 20 | Real accumulator result, registered |
| acc_im | output | 20 | Imaginary accumulator result, registered |
| growth | output | 2 | Registered growth code, 0 to 3 bits |

## Verification
The bench sweeps all 32 values of a main-result field. This exposes any off-by-one at the boundaries 0/−1, 1/−2 and 3/−4: a wrong leading-sign count would report 1 where 0 is expected, or saturate too early. It holds one field at growth 2 while the others are lower, then raises another field to growth 3. A design that ignored a source, or took an OR in place of a maximum, would miss the peak. Long runs of full-scale positive samples force the sum through +2^19. Saturating logic instead of wrapping would show a frozen output. Peak-hold periods that follow high growth with small data catch a register that falls back to the current value. A one-cycle misalignment between the sum and its growth code shows up as a code taken from the wrong sum.

// File: rtl/cag_pkg.sv
package cag_pkg;
  parameter int unsigned CAG_IN_W  = 16;
  parameter int unsigned CAG_GUARD = 4;
  parameter int unsigned CAG_GW    = 2;

  function automatic logic [CAG_GW-1:0] cag_max(input logic [CAG_GW-1:0] a,
                                                input logic [CAG_GW-1:0] b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/cag_lane.sv
module cag_lane #(
  parameter int unsigned IN_W  = 16,
  parameter int unsigned GUARD = 4,
  localparam int unsigned OUT_W = IN_W + GUARD
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_en,
  input  logic [IN_W-1:0]  smp,
  output logic [OUT_W-1:0] acc_q
);
  logic [OUT_W-1:0] smp_ext;
  logic [OUT_W-1:0] feedback;

  assign smp_ext  = {{GUARD{smp[IN_W-1]}}, smp};
  assign feedback = acc_en ? acc_q : '0;

  always_ff @(posedge clk) begin
    if (rst) acc_q <= '0;
    else     acc_q <= feedback + smp_ext;
  end
endmodule

// File: rtl/cag_growth_meas.sv
module cag_growth_meas #(
  parameter int unsigned GUARD = 4,
  parameter int unsigned GW    = 2
) (
  input  logic [GUARD:0]  top,
  output logic [GW-1:0]   g
);
  localparam int unsigned GMAX = (1 << GW) - 1;

  int unsigned same;
  int unsigned loss;
  logic        run;

  always_comb begin
    same = 0;
    run  = 1'b1;
    for (int i = int'(GUARD) - 1; i >= 0; i--) begin
      if (run && (top[i] == top[GUARD])) same = same + 1;
      else run = 1'b0;
    end
    loss = GUARD - same;
    g    = (loss > GMAX) ? GW'(GMAX) : GW'(loss);
  end
endmodule

// File: rtl/cag_peak.sv
module cag_peak #(
  parameter int unsigned GW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          track_live,
  input  logic [GW-1:0] cur_g,
  output logic [GW-1:0] peak_q
);
  always_ff @(posedge clk) begin
    if (rst)             peak_q <= '0;
    else if (track_live) peak_q <= cur_g;
    else if (cur_g > peak_q) peak_q <= cur_g;
  end
endmodule

// File: rtl/cplx_accum_growth.sv
module cplx_accum_growth
  import cag_pkg::*;
#(
  parameter int unsigned IN_W  = CAG_IN_W,
  parameter int unsigned GUARD = CAG_GUARD,
  parameter int unsigned GW    = CAG_GW,
  localparam int unsigned OUT_W = IN_W + GUARD
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IN_W-1:0]  smp_re,
  input  logic [IN_W-1:0]  smp_im,
  input  logic             acc_en,
  input  logic             track_live,
  input  logic [GUARD:0]   mac_re_hi,
  input  logic [GUARD:0]   mac_im_hi,
  output logic [OUT_W-1:0] acc_re,
  output logic [OUT_W-1:0] acc_im,
  output logic [GW-1:0]    growth
);
  localparam int unsigned NLANE = 2;
  localparam int unsigned NSRC  = 2 * NLANE;

  logic [NLANE-1:0][IN_W-1:0]  smp_v;
  logic [NLANE-1:0][OUT_W-1:0] acc_v;
  logic [NSRC-1:0][GUARD:0]    top_v;
  logic [NSRC-1:0][GW-1:0]     g_v;
  logic [GW-1:0]               cur_g;

  assign smp_v = {smp_im, smp_re};

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    cag_lane #(.IN_W(IN_W), .GUARD(GUARD)) lane_i (
      .clk    (clk),
      .rst    (rst),
      .acc_en (acc_en),
      .smp    (smp_v[l]),
      .acc_q  (acc_v[l])
    );
    assign top_v[l] = acc_v[l][OUT_W-1 -: GUARD+1];
  end

  assign top_v[NLANE]   = mac_re_hi;
  assign top_v[NLANE+1] = mac_im_hi;

  for (genvar s = 0; s < NSRC; s++) begin : g_meas
    cag_growth_meas #(.GUARD(GUARD), .GW(GW)) meas_i (
      .top (top_v[s]),
      .g   (g_v[s])
    );
  end

  always_comb begin
    cur_g = '0;
    for (int s = 0; s < int'(NSRC); s++) cur_g = cag_max(cur_g, g_v[s]);
  end

  cag_peak #(.GW(GW)) peak_i (
    .clk        (clk),
    .rst        (rst),
    .track_live (track_live),
    .cur_g      (cur_g),
    .peak_q     (growth)
  );

  assign acc_re = acc_v[0];
  assign acc_im = acc_v[1];
endmodule

// File: rtl/cag_checker.sv
module cag_checker #(
  parameter int unsigned IN_W  = 16,
  parameter int unsigned GUARD = 4,
  parameter int unsigned GW    = 2,
  localparam int unsigned OUT_W = IN_W + GUARD
) (
  input logic             clk,
  input logic             rst,
  input logic [IN_W-1:0]  smp_re,
  input logic [IN_W-1:0]  smp_im,
  input logic             acc_en,
  input logic             track_live,
  input logic [OUT_W-1:0] acc_re,
  input logic [OUT_W-1:0] acc_im,
  input logic [GW-1:0]    growth,
  input logic [GW-1:0]    cur_g
);
  // R1
  p_reset_clear_r1: assert property (@(posedge clk)
    $past(rst) |-> (acc_re == '0 && acc_im == '0 && growth == '0));

  // R2
  p_load_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(acc_en)) |->
      (acc_re == $past({{GUARD{smp_re[IN_W-1]}}, smp_re})));

  // R3 and R9: modular sum
  p_accum_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(acc_en)) |->
      (acc_re == OUT_W'($past(acc_re) + $past({{GUARD{smp_re[IN_W-1]}}, smp_re}))));

  // R4
  p_imag_lane_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(acc_en)) |->
      (acc_im == OUT_W'($past(acc_im) + $past({{GUARD{smp_im[IN_W-1]}}, smp_im}))));

  // R7
  p_follow_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(track_live)) |-> (growth == $past(cur_g)));

  // R8
  p_peak_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(track_live)) |->
      (growth >= $past(growth) && growth >= $past(cur_g)));
endmodule

bind cplx_accum_growth cag_checker #(.IN_W(IN_W), .GUARD(GUARD), .GW(GW)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .smp_re     (smp_re),
  .smp_im     (smp_im),
  .acc_en     (acc_en),
  .track_live (track_live),
  .acc_re     (acc_re),
  .acc_im     (acc_im),
  .growth     (growth),
  .cur_g      (cur_g)
);

// File: tb/cplx_accum_growth_tb_top.sv
`timescale 1ns/1ps
module cplx_accum_growth_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] smp_re = '0, smp_im = '0;
  logic        acc_en = 1'b0, track_live = 1'b1;
  logic [4:0]  mac_re_hi = '0, mac_im_hi = '0;
  logic [19:0] acc_re, acc_im;
  logic [1:0]  growth;

  int total = 0;
  int bad   = 0;
  logic [19:0] m_re = '0, m_im = '0;
  int          m_g  = 0;

  always #4 clk = ~clk;

  cplx_accum_growth dut_i (
    .clk(clk), .rst(rst), .smp_re(smp_re), .smp_im(smp_im),
    .acc_en(acc_en), .track_live(track_live),
    .mac_re_hi(mac_re_hi), .mac_im_hi(mac_im_hi),
    .acc_re(acc_re), .acc_im(acc_im), .growth(growth)
  );

  function automatic int gval(input logic signed [19:0] v);
    if (v >= -32768  && v < 32768)  return 0;
    if (v >= -65536  && v < 65536)  return 1;
    if (v >= -131072 && v < 131072) return 2;
    return 3;
  endfunction

  function automatic int gtop(input logic signed [4:0] s);
    if (s >= -1 && s <= 0) return 0;
    if (s >= -2 && s <= 1) return 1;
    if (s >= -4 && s <= 3) return 2;
    return 3;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [15:0] re, input logic [15:0] im,
                      input logic ae, input logic tl,
                      input logic [4:0] mr, input logic [4:0] mi,
                      input string ta, input string tg);
    int cur;
    @(negedge clk);
    smp_re = re; smp_im = im; acc_en = ae; track_live = tl;
    mac_re_hi = mr; mac_im_hi = mi;
    @(posedge clk);
    #1;
    cur = imax(imax(gval(m_re), gval(m_im)), imax(gtop(mr), gtop(mi)));
    m_g = tl ? cur : imax(m_g, cur);
    m_re = (ae ? m_re : 20'd0) + {{4{re[15]}}, re};
    m_im = (ae ? m_im : 20'd0) + {{4{im[15]}}, im};
    #2;
    check(ta != "" ? ta : (ae ? "R3" : "R2"), int'(acc_re), int'(m_re));
    check("R4", int'(acc_im), int'(m_im));
    check(tg != "" ? tg : (tl ? "R7" : "R8"), int'(growth), m_g);
  endtask

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R1: state after reset
    check("R1", int'(acc_re), 0);
    check("R1", int'(acc_im), 0);
    check("R1", int'(growth), 0);

    // R2: load negative full scale
    step(16'h8000, 16'h7FFF, 1'b0, 1'b1, 5'd0, 5'd0, "R2", "");
    step(16'h0000, 16'h0000, 1'b0, 1'b1, 5'd0, 5'd0, "R2", "");

    // R5: sweep every main-result field value
    for (int s = 0; s < 32; s++)
      step(16'h0000, 16'h0000, 1'b0, 1'b1, 5'(s), 5'd0, "", "R5");
    for (int s = 0; s < 32; s++)
      step(16'h0000, 16'h0000, 1'b0, 1'b1, 5'd0, 5'(s), "", "R5");

    // R6: max over sources, accumulator grows to 2 bits
    step(16'h7FFF, 16'h0001, 1'b0, 1'b1, 5'b00011, 5'd0, "", "R6");
    step(16'h7FFF, 16'h0001, 1'b1, 1'b1, 5'b00001, 5'd0, "", "R6");
    step(16'h7FFF, 16'h0001, 1'b1, 1'b1, 5'd0, 5'd0, "", "R6");
    step(16'h0000, 16'h0000, 1'b1, 1'b1, 5'd0, 5'b11111, "", "R6");
    step(16'h0000, 16'h0000, 1'b1, 1'b1, 5'b10000, 5'd0, "", "R6");
    step(16'h0000, 16'h0000, 1'b1, 1'b1, 5'd0, 5'd0, "", "R6");

    // R8: peak hold then small data
    step(16'h0000, 16'h0000, 1'b0, 1'b0, 5'd0, 5'd0, "", "R8");
    step(16'h0000, 16'h0000, 1'b0, 1'b0, 5'b01000, 5'd0, "", "R8");
    step(16'h0000, 16'h0000, 1'b0, 1'b0, 5'd0, 5'd0, "", "R8");
    step(16'h0000, 16'h0000, 1'b0, 1'b1, 5'd0, 5'd0, "", "R7");

    // R9: drive the sum through both ends of the range
    step(16'h7FFF, 16'h8000, 1'b0, 1'b1, 5'd0, 5'd0, "R9", "");
    for (int k = 0; k < 40; k++)
      step(16'h7FFF, 16'h8000, 1'b1, k[2], 5'd0, 5'd0, "R9", "");

    // Random mix
    for (int k = 0; k < 1500; k++) begin
      logic [15:0] rr, ri;
      logic        ae, tl;
      rr = 16'($urandom);
      ri = 16'($urandom);
      if ($urandom_range(0, 3) == 0) begin
        rr = 16'h7FFF;
        ri = 16'h8000;
      end
      ae = ($urandom_range(0, 9) != 0);
      tl = ($urandom_range(0, 3) == 0);
      step(rr, ri, ae, tl, 5'($urandom), ($urandom_range(0, 1) == 0) ? 5'd0 : 5'($urandom), "", "");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule